// File: doc/BRIEF.md
# Shared Cache Control Register with Idle Retention Timer

This block holds one 32-bit control and status word for a shared second-level cache. Two sticky flags record error events. One is a double-bit ECC error from the cache RAM. The other is an asynchronous error from the external interconnect. Software clears a flag by writing 0 to its bit. A 3-bit field selects how many timer ticks the cache must stay idle before the block asks the power controller to enter retention. One instance serves both security states, and software may rewrite it at any time.

Every access carries a 2-bit privilege level. Level 0 is the least privileged and has no access. Levels 1, 2 and 3 may read and write. A denied access reads zero, changes nothing, and raises a fault pulse. The idle timer counts tick pulses only while the idle input is high. Once the count reaches the selected threshold, the block holds a retention request until idle drops or software reprograms the word.

Top module: `l2_ctrl_status_reg`

## Requirements
- R1: After reset, every stored bit is 0, `ret_req` and `bus_fault` are low, and both flag outputs are low.
- R2: A pulse on `ecc_dbl_err` sets the RAM error flag on the next clock edge. The flag appears on `ecc_err_flag` and at readback bit 30.
- R3: A pulse on `ic_async_err` sets the interconnect error flag on the next clock edge. The flag appears on `ic_err_flag` and at readback bit 29.
- R4: A permitted write with 0 in bit 30 (or bit 29) clears that flag. A write with 1 in that bit leaves the flag unchanged.
- R5: If an error event and a clearing write to the same flag fall in the same cycle, the flag is 1 afterwards.
- R6: Bit 31 and bits 28 to 3 always read 0, whatever value was written to them.
- R7: An access with `bus_priv` = 0 reads 0 and leaves all state unchanged. `bus_fault` is high for exactly the next cycle.
- R8: A permitted write (`bus_priv` ≠ 0) stores `bus_wdata[2:0]` as the retention code. A permitted read (`bus_wr` = 0) returns the current word on `bus_rdata` in the same cycle. At all other times `bus_rdata` is 0.
- R9: The retention code sets the tick threshold: 1→2, 2→8, 3→32, 4→64, 5→128, 6→256, 7→512. `ret_req` rises right after the clock edge that takes the threshold-th tick seen with `l2_idle` high.
- R10: Ticks count only while `l2_idle` is high. When `l2_idle` is low, `ret_req` is low in that same cycle and the count restarts from zero.
- R11: Every permitted write restarts the count. With code 0, `ret_req` never asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe for this register |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 2 | Privilege level of the access, 0 = least privileged |
| bus_wdata | input | 32 | Write data |
| ecc_dbl_err | input | 1 | Pulse: double-bit ECC error in cache RAM |
| ic_async_err | input | 1 | Pulse: asynchronous interconnect error |
| tick | input | 1 | Periodic timer tick pulse |
| l2_idle | input | 1 | Cache idle indication |
| bus_rdata | output | 32 | Read data (zero unless a permitted read) |
| bus_fault | output | 1 | One-cycle pulse after a denied access |
| ecc_err_flag | output | 1 | Sticky RAM error flag |
| ic_err_flag | output | 1 | Sticky interconnect error flag |
| ret_req | output | 1 | Retention request |

## Verification
The hardest situation to reach is the largest threshold: 512 ticks must arrive with idle held high and no write in between. Random traffic almost never provides that. A directed run therefore programs code 7 and drives exactly 511 ticks, then confirms that the request is still low. It drives one more tick and expects the request. Clearing writes that coincide with error events are also rare by chance, so directed cycles place both on the same edge. The random phase then mixes short codes, frequent ticks, idle dropouts and unprivileged accesses against a model kept in the bench.

// File: rtl/l2csr_pkg.sv
package l2csr_pkg;

   localparam int unsigned REG_W   = 32;
   localparam int unsigned PRIV_W  = 2;
   localparam int unsigned CODE_W  = 3;
   localparam int unsigned N_FLAGS = 2;

   typedef logic [PRIV_W-1:0] priv_t;
   typedef logic [CODE_W-1:0] ret_code_t;

   localparam priv_t PRIV_DENIED = '0;

   // Exponent of the tick threshold for a nonzero retention code.
   function automatic int unsigned code_to_shift(input ret_code_t c);
      int unsigned s;
      case (c)
         3'd1:    s = 1;
         3'd2:    s = 3;
         default: s = 32'(c) + 2;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/l2csr_err_flag.sv
module l2csr_err_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic event_i,
   input  logic clr_i,
   output logic flag_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_o <= 1'b0;
      else if (event_i) flag_o <= 1'b1;
      else if (clr_i)   flag_o <= 1'b0;
   end

   assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      event_i |=> flag_o);

   assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o);

   assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_o && !event_i) |=> !flag_o);

endmodule

// File: rtl/l2csr_thresh_decode.sv
module l2csr_thresh_decode
   import l2csr_pkg::*;
#(
   parameter int unsigned CNT_W = 10
) (
   input  ret_code_t        code_i,
   output logic             en_o,
   output logic [CNT_W-1:0] thr_o
);

   localparam int unsigned MAX_SHIFT = 2 ** CODE_W + 1;

   initial begin
      assert (CNT_W > MAX_SHIFT)
         else $error("CNT_W too small for the largest retention threshold");
   end

   always_comb begin
      en_o  = (code_i != '0);
      thr_o = '0;
      if (en_o) thr_o = CNT_W'(1) << code_to_shift(code_i);
   end

endmodule

// File: rtl/l2csr_idle_timer.sv
module l2csr_idle_timer #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             idle_i,
   input  logic             restart_i,
   input  logic             en_i,
   input  logic [CNT_W-1:0] thr_i,
   output logic             req_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             at_thr;

   assign at_thr = (cnt_q >= thr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             cnt_q <= '0;
      else if (!idle_i || restart_i || !en_i) cnt_q <= '0;
      else if (tick_i && !at_thr)             cnt_q <= cnt_q + 1'b1;
   end

   assign req_o = idle_i && en_i && at_thr;

   assert_idle_drop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !idle_i |=> (cnt_q == '0));

   assert_count_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |-> (cnt_q <= thr_i));

   assert_restart_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (cnt_q == '0));

   assert_no_tick_no_move_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_i && !tick_i && !restart_i && en_i) |=> $stable(cnt_q));

endmodule

// File: rtl/l2_ctrl_status_reg.sv
module l2_ctrl_status_reg
   import l2csr_pkg::*;
#(
   parameter int unsigned ECC_BIT = 30,
   parameter int unsigned IC_BIT  = 29,
   parameter int unsigned CNT_W   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [PRIV_W-1:0] bus_priv,
   input  logic [REG_W-1:0]  bus_wdata,
   input  logic              ecc_dbl_err,
   input  logic              ic_async_err,
   input  logic              tick,
   input  logic              l2_idle,
   output logic [REG_W-1:0]  bus_rdata,
   output logic              bus_fault,
   output logic              ecc_err_flag,
   output logic              ic_err_flag,
   output logic              ret_req
);

   initial begin
      assert (ECC_BIT < REG_W && IC_BIT < REG_W)
         else $error("flag bit outside register");
      assert (ECC_BIT != IC_BIT)
         else $error("flag bits overlap");
      assert (ECC_BIT >= CODE_W && IC_BIT >= CODE_W)
         else $error("flag bit overlaps retention code");
   end

   logic              acc_ok, acc_deny, wr_ok, rd_ok;
   ret_code_t         code_q;
   logic [N_FLAGS-1:0] flag_ev, flag_clr, flag_q;
   logic [REG_W-1:0]  word;
   logic              thr_en;
   logic [CNT_W-1:0]  thr;

   assign acc_ok   = bus_sel && (bus_priv != PRIV_DENIED);
   assign acc_deny = bus_sel && (bus_priv == PRIV_DENIED);
   assign wr_ok    = acc_ok && bus_wr;
   assign rd_ok    = acc_ok && !bus_wr;

   assign flag_ev = {ic_async_err, ecc_dbl_err};

   for (genvar gi = 0; gi < N_FLAGS; gi++) begin : g_flag
      localparam int unsigned POS = (gi == 0) ? ECC_BIT : IC_BIT;
      assign flag_clr[gi] = wr_ok && !bus_wdata[POS];
      l2csr_err_flag u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .event_i(flag_ev[gi]),
         .clr_i  (flag_clr[gi]),
         .flag_o (flag_q[gi])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     code_q <= '0;
      else if (wr_ok) code_q <= bus_wdata[CODE_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_fault <= 1'b0;
      else        bus_fault <= acc_deny;
   end

   always_comb begin
      word                = '0;
      word[CODE_W-1:0]    = code_q;
      word[ECC_BIT]       = flag_q[0];
      word[IC_BIT]        = flag_q[1];
      bus_rdata           = rd_ok ? word : '0;
   end

   assign ecc_err_flag = flag_q[0];
   assign ic_err_flag  = flag_q[1];

   l2csr_thresh_decode #(.CNT_W(CNT_W)) u_dec (
      .code_i(code_q),
      .en_o  (thr_en),
      .thr_o (thr)
   );

   l2csr_idle_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick),
      .idle_i   (l2_idle),
      .restart_i(wr_ok),
      .en_i     (thr_en),
      .thr_i    (thr),
      .req_o    (ret_req)
   );

   assert_denied_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_deny |=> bus_fault);

   assert_denied_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_deny && !ecc_dbl_err && !ic_async_err) |=>
         ($stable(code_q) && $stable(flag_q)));

   assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata[REG_W-1] == 1'b0) && (bus_rdata[IC_BIT-1:CODE_W] == '0));

   assert_code_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q == '0) |-> !ret_req);

   assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(l2_idle) |-> !ret_req);

   assert_write_stores_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> (code_q == $past(bus_wdata[CODE_W-1:0])));

endmodule

// File: tb/l2_ctrl_status_reg_tb.sv
`timescale 1ns/1ps
module l2_ctrl_status_reg_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [1:0]  bus_priv = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic        ecc_dbl_err = 1'b0, ic_async_err = 1'b0, tick = 1'b0, l2_idle = 1'b0;
   logic [31:0] bus_rdata;
   logic        bus_fault, ecc_err_flag, ic_err_flag, ret_req;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   logic       m_ecc, m_ic, m_fault;
   logic [2:0] m_code;
   int         m_cnt;

   always #2.5 clk = ~clk;

   l2_ctrl_status_reg u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_priv(bus_priv), .bus_wdata(bus_wdata), .ecc_dbl_err(ecc_dbl_err),
      .ic_async_err(ic_async_err), .tick(tick), .l2_idle(l2_idle),
      .bus_rdata(bus_rdata), .bus_fault(bus_fault), .ecc_err_flag(ecc_err_flag),
      .ic_err_flag(ic_err_flag), .ret_req(ret_req)
   );

   function automatic int thr_of(input logic [2:0] c);
      case (c)
         3'd0: return 0;
         3'd1: return 2;
         3'd2: return 8;
         3'd3: return 32;
         3'd4: return 64;
         3'd5: return 128;
         3'd6: return 256;
         default: return 512;
      endcase
   endfunction

   function automatic logic [31:0] word_of(input logic e, input logic i, input logic [2:0] c);
      logic [31:0] w;
      w = '0;
      w[30] = e;
      w[29] = i;
      w[2:0] = c;
      return w;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // One cycle: drive at negedge, check combinational outputs, advance model, check registered outputs.
   task automatic step(input logic sel, input logic [1:0] priv, input logic wr,
                       input logic [31:0] wd, input logic ee, input logic ie,
                       input logic tk, input logic idl);
      logic ok, deny, rd, wrk;
      int   t;
      @(negedge clk);
      bus_sel = sel; bus_priv = priv; bus_wr = wr; bus_wdata = wd;
      ecc_dbl_err = ee; ic_async_err = ie; tick = tk; l2_idle = idl;
      #1;
      ok   = sel && (priv != 2'd0);
      deny = sel && (priv == 2'd0);
      rd   = ok && !wr;
      wrk  = ok && wr;
      t    = thr_of(m_code);
      chk("R8 readback", bus_rdata, rd ? word_of(m_ecc, m_ic, m_code) : 32'h0);
      chk("R9 ret_req", {31'b0, ret_req}, {31'b0, idl && (m_code != 0) && (m_cnt >= t)});
      m_ecc = ee | (m_ecc & !(wrk && !wd[30]));
      m_ic  = ie | (m_ic  & !(wrk && !wd[29]));
      if (!idl || wrk || m_code == 0) m_cnt = 0;
      else if (tk && m_cnt < t)       m_cnt = m_cnt + 1;
      if (wrk) m_code = wd[2:0];
      m_fault = deny;
      @(posedge clk);
      #1;
      chk("R2 ecc flag", {31'b0, ecc_err_flag}, {31'b0, m_ecc});
      chk("R3 ic flag",  {31'b0, ic_err_flag},  {31'b0, m_ic});
      chk("R7 fault",    {31'b0, bus_fault},    {31'b0, m_fault});
   endtask

   task automatic wr_reg(input logic [31:0] d, input logic idl);
      step(1, 2'd1, 1, d, 0, 0, 0, idl);
   endtask

   task automatic idle_cyc(input logic tk, input logic idl);
      step(0, 2'd0, 0, 32'h0, 0, 0, tk, idl);
   endtask

   task automatic rd_expect(input string tag, input logic [31:0] exp);
      @(negedge clk);
      bus_sel = 1; bus_priv = 2'd3; bus_wr = 0; bus_wdata = 0;
      ecc_dbl_err = 0; ic_async_err = 0; tick = 0;
      #1;
      chk(tag, bus_rdata, exp);
      @(posedge clk);
      #1;
      bus_sel = 0;
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
      m_ecc = 0; m_ic = 0; m_code = 0; m_cnt = 0; m_fault = 0;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk("R1 rdata", bus_rdata, 32'h0);
      chk("R1 ret_req", {31'b0, ret_req}, 32'h0);
      chk("R1 flags", {30'b0, ecc_err_flag, ic_err_flag}, 32'h0);
      chk("R1 fault", {31'b0, bus_fault}, 32'h0);
      rst_n = 1'b1;
      rd_expect("R1 stored word", 32'h0);

      // R9: code 1, two idle ticks
      wr_reg(32'h1, 1);
      idle_cyc(1, 1);
      chk("R9 one tick not enough", {31'b0, ret_req}, 32'h0);
      idle_cyc(1, 1);
      chk("R9 request after 2 ticks", {31'b0, ret_req}, 32'h1);
      // R10: idle drop
      @(negedge clk); l2_idle = 0; #1;
      chk("R10 idle low same cycle", {31'b0, ret_req}, 32'h0);
      idle_cyc(0, 0);
      idle_cyc(1, 1);
      chk("R10 restart from zero", {31'b0, ret_req}, 32'h0);
      idle_cyc(0, 0);
      idle_cyc(1, 0);
      idle_cyc(1, 0);
      chk("R10 ticks ignored when busy", {31'b0, ret_req}, 32'h0);

      // R2/R3/R6/R4: set flags, write ones everywhere
      step(0, 0, 0, 0, 1, 0, 0, 0);
      step(0, 0, 0, 0, 0, 1, 0, 0);
      wr_reg(32'hFFFF_FFFF, 0);
      rd_expect("R6 R4 reserved zero, ones keep flags", 32'h6000_0007);
      wr_reg(32'h2000_0007, 0);
      rd_expect("R4 zero clears bit 30 only", 32'h2000_0007);

      // R5: event with clearing write in same cycle
      step(1, 2'd2, 1, 32'h0000_0003, 1, 1, 0, 0);
      rd_expect("R5 event beats clear", 32'h6000_0003);

      // R7: denied access
      step(1, 2'd0, 1, 32'h0, 0, 0, 0, 0);
      chk("R7 fault pulse", {31'b0, bus_fault}, 32'h1);
      idle_cyc(0, 0);
      chk("R7 fault one cycle", {31'b0, bus_fault}, 32'h0);
      @(negedge clk); bus_sel = 1; bus_priv = 0; bus_wr = 0; #1;
      chk("R7 denied read zero", bus_rdata, 32'h0);
      @(posedge clk); #1; m_fault = 1; bus_sel = 0;
      chk("R7 read fault", {31'b0, bus_fault}, 32'h1);
      rd_expect("R7 state unchanged", 32'h6000_0003);
      wr_reg(32'h0, 0);

      // R9: largest threshold
      wr_reg(32'h7, 1);
      for (int k = 0; k < 511; k++) idle_cyc(1, 1);
      chk("R9 511 ticks no request", {31'b0, ret_req}, 32'h0);
      idle_cyc(1, 1);
      chk("R9 512 ticks request", {31'b0, ret_req}, 32'h1);
      // R11: write code 0 drops request
      wr_reg(32'h0, 1);
      chk("R11 code 0 off", {31'b0, ret_req}, 32'h0);
      for (int k = 0; k < 20; k++) idle_cyc(1, 1);
      chk("R11 stays off", {31'b0, ret_req}, 32'h0);
      // R11: write restarts count
      wr_reg(32'h2, 1);
      for (int k = 0; k < 7; k++) idle_cyc(1, 1);
      wr_reg(32'h2, 1);
      idle_cyc(1, 1);
      chk("R11 write restarted count", {31'b0, ret_req}, 32'h0);

      // Random phase
      for (int n = 0; n < 4000; n++) begin
         logic        s, w, ee, ie, tk, idl;
         logic [1:0]  p;
         logic [31:0] d;
         s   = ($urandom % 6) == 0;
         p   = 2'($urandom);
         w   = $urandom % 2;
         d   = $urandom;
         if (($urandom % 4) != 0) d[2:0] = 3'(1 + $urandom % 3);
         ee  = ($urandom % 20) == 0;
         ie  = ($urandom % 20) == 0;
         tk  = ($urandom % 2) == 0;
         idl = ($urandom % 25) != 0;
         step(s, p, w, d, ee, ie, tk, idl);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule